// File: doc/BRIEF.md
# Asynchronous Serial Port Mode Register

This block holds the byte-wide operating mode of an asynchronous serial port and turns it into the control signals that the port's transmitter and receiver consume. Software writes it over a simple strobe bus, either as a whole byte or one bit at a time, and reads the stored byte back.

The top bit works as a master switch. While it is clear, the port's operation clock is held low, the port logic is held in asynchronous reset, the status and receive-buffer registers are told to clear, the transmit pin is parked at its idle level, and the receiver sees a constant high input. The transmit and receive enable bits sit one level below it. Each one only issues a synchronous reset to its own direction. The low five bits are decoded into frame configuration outputs: parity mode, character length, stop-bit count and a reception-interrupt option.

Top module: `uart_mode_ctl`

## Requirements
- R1: After reset the register reads 0x01, and rd_data always returns the stored byte.
- R2: When wr_en is high and wr_bit_mode is low, all eight bits take wr_data at the next clock edge. When wr_en and wr_bit_mode are both high, only bit wr_bit_sel takes wr_data[0] and the other bits keep their values. When wr_en is low, the register holds.
- R3: Field decode: bit 7 is power, bit 6 is transmit enable, bit 5 is receive enable, bits 4:3 drive par_mode, bit 2 drives char_len, bit 1 drives stop_sel and bit 0 drives rx_irq_mode.
- R4: tx_en_eff equals power AND transmit enable. rx_en_eff equals power AND receive enable.
- R5: tx_path_rst is high only while power is 1 and transmit enable is 0. rx_path_rst is high only while power is 1 and receive enable is 0. Neither one depends on the other direction's enable bit.
- R6: While power is 0, port_rst_n is low and op_clk stays low. While power is 1, port_rst_n follows rst_n and op_clk follows clk.
- R7: status_clr is high exactly while power is 0. This clears the error status, the transmit status, the break flags and the receive buffer.
- R8: While power is 0, txd_pin sits at the idle level, which is 1 when out_invert is 0 and 0 when out_invert is 1. While power is 1, txd_pin equals tx_core XOR out_invert.
- R9: While power is 0, rxd_core is 1. While power is 1, rxd_core equals rxd_pin.
- R10: Writing the value already stored, as a byte or as a bit, leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_bit_mode | input | 1 | 1 selects a single-bit write |
| wr_bit_sel | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Write data; bit 0 is used for a single-bit write |
| rd_data | output | 8 | Stored mode byte |
| out_invert | input | 1 | Transmit output inversion option |
| tx_core | input | 1 | Serial output from the transmitter |
| rxd_pin | input | 1 | Receive pin |
| txd_pin | output | 1 | Transmit pin |
| rxd_core | output | 1 | Receive data delivered to the receiver |
| op_clk | output | 1 | Gated operation clock |
| port_rst_n | output | 1 | Asynchronous port reset, active low |
| status_clr | output | 1 | Clear for the status and receive-buffer registers |
| tx_en_eff | output | 1 | Effective transmit enable |
| rx_en_eff | output | 1 | Effective receive enable |
| tx_path_rst | output | 1 | Synchronous reset of the transmit path |
| rx_path_rst | output | 1 | Synchronous reset of the receive path |
| par_mode | output | 2 | Parity mode field |
| char_len | output | 1 | Character length select |
| stop_sel | output | 1 | Stop-bit count select |
| rx_irq_mode | output | 1 | Reception interrupt mode option |

## Verification
The assertions check on every cycle that the register updates correctly for byte writes, bit writes and idle cycles. They also check that the effective enables and path resets match the power bit, that the receiver input and the transmit idle level are forced while power is off, and that a same-value rewrite leaves the enables steady. Some behaviour only the bench scenarios can show: the register's reset value, the decoding of each field, the interaction of the inversion option with a live transmitter output, and the gated clock staying low through its high phase. They do this by driving sequences of writes and pin levels and comparing every output against an independent model.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;
    localparam int REG_W      = 8;
    localparam int SEL_W      = $clog2(REG_W);
    localparam int POS_PWR    = 7;
    localparam int POS_TXE    = 6;
    localparam int POS_RXE    = 5;
    localparam int POS_PAR_HI = 4;
    localparam int POS_PAR_LO = 3;
    localparam int POS_CL     = 2;
    localparam int POS_SL     = 1;
    localparam int POS_IRQ    = 0;
    localparam logic [REG_W-1:0] MODE_RST = 8'h01;

    typedef struct packed {
        logic [REG_W-1:0] mode;
    } mode_state_t;
endpackage

// File: rtl/umr_regfile.sv
module umr_regfile
    import uart_mode_pkg::*;
#(
    parameter int W = REG_W,
    parameter logic [W-1:0] RST_VAL = MODE_RST,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bit_mode,
    input  logic [SW-1:0] wr_bit_sel,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  mode_q
);
    logic [W-1:0] mode_d, mode_r;

    always_comb begin
        mode_d = mode_r;
        if (wr_en) begin
            if (wr_bit_mode) mode_d[wr_bit_sel] = wr_data[0];
            else             mode_d = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_r <= RST_VAL;
        else        mode_r <= mode_d;
    end

    assign mode_q = mode_r;

    // R2
    byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit_mode) |=> (mode_q == $past(wr_data)));
    // R2
    bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit_mode) |=> (mode_q[$past(wr_bit_sel)] == $past(wr_data[0])));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/umr_enable.sv
module umr_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    input  logic txe,
    input  logic rxe,
    output logic op_clk,
    output logic port_rst_n,
    output logic status_clr,
    output logic tx_en_eff,
    output logic rx_en_eff,
    output logic tx_path_rst,
    output logic rx_path_rst
);
    assign op_clk      = clk & pwr;
    assign port_rst_n  = rst_n & pwr;
    assign status_clr  = ~pwr;
    assign tx_en_eff   = pwr & txe;
    assign rx_en_eff   = pwr & rxe;
    assign tx_path_rst = pwr & ~txe;
    assign rx_path_rst = pwr & ~rxe;
endmodule

// File: rtl/umr_pins.sv
module umr_pins (
    input  logic pwr,
    input  logic out_invert,
    input  logic tx_core,
    input  logic rxd_pin,
    output logic txd_pin,
    output logic rxd_core
);
    logic tx_level;
    assign tx_level = pwr ? tx_core : 1'b1;
    assign txd_pin  = tx_level ^ out_invert;
    assign rxd_core = pwr ? rxd_pin : 1'b1;
endmodule

// File: rtl/uart_mode_ctl.sv
module uart_mode_ctl
    import uart_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit_mode,
    input  logic [SEL_W-1:0] wr_bit_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             out_invert,
    input  logic             tx_core,
    input  logic             rxd_pin,
    output logic             txd_pin,
    output logic             rxd_core,
    output logic             op_clk,
    output logic             port_rst_n,
    output logic             status_clr,
    output logic             tx_en_eff,
    output logic             rx_en_eff,
    output logic             tx_path_rst,
    output logic             rx_path_rst,
    output logic [1:0]       par_mode,
    output logic             char_len,
    output logic             stop_sel,
    output logic             rx_irq_mode
);
    logic [REG_W-1:0] mode_q;
    logic pwr;

    umr_regfile #(.W(REG_W), .RST_VAL(MODE_RST)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit_mode(wr_bit_mode),
        .wr_bit_sel(wr_bit_sel), .wr_data(wr_data), .mode_q(mode_q)
    );

    assign pwr = mode_q[POS_PWR];

    umr_enable en_i (
        .clk(clk), .rst_n(rst_n), .pwr(pwr),
        .txe(mode_q[POS_TXE]), .rxe(mode_q[POS_RXE]),
        .op_clk(op_clk), .port_rst_n(port_rst_n), .status_clr(status_clr),
        .tx_en_eff(tx_en_eff), .rx_en_eff(rx_en_eff),
        .tx_path_rst(tx_path_rst), .rx_path_rst(rx_path_rst)
    );

    umr_pins pins_i (
        .pwr(pwr), .out_invert(out_invert), .tx_core(tx_core),
        .rxd_pin(rxd_pin), .txd_pin(txd_pin), .rxd_core(rxd_core)
    );

    assign rd_data     = mode_q;
    assign par_mode    = mode_q[POS_PAR_HI:POS_PAR_LO];
    assign char_len    = mode_q[POS_CL];
    assign stop_sel    = mode_q[POS_SL];
    assign rx_irq_mode = mode_q[POS_IRQ];

    // R4
    tx_eff_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_eff |-> (rd_data[POS_PWR] && !tx_path_rst));
    // R5
    path_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_path_rst || rx_path_rst) |-> (port_rst_n && !status_clr));
    // R9
    rx_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |-> rxd_core);
    // R8
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |-> (txd_pin == !out_invert));
    // R6
    arst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |-> !port_rst_n);
    // R10
    rewrite_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit_mode && wr_data == rd_data) |=>
            ($stable(tx_en_eff) && $stable(rx_en_eff) && $stable(status_clr)));
endmodule

// File: tb/uart_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_mode_ctl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_bit_mode = 1'b0;
    logic [2:0] wr_bit_sel = '0;
    logic [7:0] wr_data = '0;
    logic out_invert = 1'b0, tx_core = 1'b1, rxd_pin = 1'b1;
    logic [7:0] rd_data;
    logic txd_pin, rxd_core, op_clk, port_rst_n, status_clr;
    logic tx_en_eff, rx_en_eff, tx_path_rst, rx_path_rst;
    logic [1:0] par_mode;
    logic char_len, stop_sel, rx_irq_mode;

    always #2.5 clk = ~clk;

    uart_mode_ctl dut_i (.*);

    int checks = 0, fails = 0;
    logic [7:0] m = 8'h01;

    typedef struct {
        logic [20:0] v;
        string req;
    } item_t;
    item_t q[$];

    function automatic logic [20:0] model();
        logic p = m[7];
        return {m, p & m[6], p & m[5], p & ~m[6], p & ~m[5], p, ~p,
                (p ? tx_core : 1'b1) ^ out_invert, p ? rxd_pin : 1'b1,
                m[4:3], m[2], m[1], m[0]};
    endfunction

    function automatic logic [20:0] observed();
        return {rd_data, tx_en_eff, rx_en_eff, tx_path_rst, rx_path_rst,
                port_rst_n, status_clr, txd_pin, rxd_core, par_mode,
                char_len, stop_sel, rx_irq_mode};
    endfunction

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            #1;
            it = q.pop_front();
            checks++;
            if (observed() !== it.v) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.req, observed(), it.v);
            end
        end
    end

    task automatic push(string req);
        item_t it;
        it.v = model();
        it.req = req;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic wr_byte(logic [7:0] d, string req);
        @(negedge clk);
        wr_en = 1'b1; wr_bit_mode = 1'b0; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m = d;
        push(req);
    endtask

    task automatic wr_bit(int idx, logic b, string req);
        @(negedge clk);
        wr_en = 1'b1; wr_bit_mode = 1'b1; wr_bit_sel = 3'(idx); wr_data = {7'h55, b};
        @(posedge clk); #1;
        wr_en = 1'b0;
        m[idx] = b;
        push(req);
    endtask

    task automatic pins(logic inv, logic txc, logic rxp, string req);
        @(negedge clk);
        out_invert = inv; tx_core = txc; rxd_pin = rxp;
        @(posedge clk); #1;
        push(req);
    endtask

    task automatic chk_clk(string req);
        @(posedge clk); #1;
        checks++;
        if (op_clk !== m[7]) begin
            fails++;
            $display("FAIL %s: op_clk actual %b expected %b", req, op_clk, m[7]);
        end
    endtask

    initial begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push("R1 reset value, R7 clear while off, R9 rx forced");
        chk_clk("R6 clock low while off");
        pins(1'b0, 1'b0, 1'b0, "R8 tx idle high, R9 rx high while off");
        pins(1'b1, 1'b0, 1'b0, "R8 tx idle low with inversion");
        pins(1'b0, 1'b0, 1'b1, "R8 restore");
        wr_byte(8'hE0, "R4 enables on, R6 port out of reset");
        chk_clk("R6 clock runs while on");
        pins(1'b0, 1'b0, 1'b0, "R8 tx passes core, R9 rx passes pin");
        pins(1'b1, 1'b0, 1'b1, "R8 inverted tx with power on");
        pins(1'b0, 1'b1, 1'b1, "R8 idle again");
        wr_bit(6, 1'b0, "R5 tx path reset only, R2 bit write");
        wr_bit(5, 1'b0, "R5 rx path reset too");
        wr_bit(6, 1'b1, "R5 tx back on, rx still reset");
        wr_byte(8'h9E, "R3 fields parity 3 len 1 stop 1 irq 0");
        wr_byte(8'hAB, "R3 fields parity 1 len 0 stop 1 irq 1");
        wr_bit(0, 1'b0, "R2 single bit clear keeps others");
        wr_byte(8'hEA, "R4 both enabled");
        pins(1'b0, 1'b0, 1'b0, "R8 mid frame low");
        wr_byte(8'hEA, "R10 byte rewrite no change");
        wr_bit(7, 1'b1, "R10 bit rewrite no change");
        wr_bit(7, 1'b0, "R6 power off mid frame, R7 clear, R8 tx high");
        chk_clk("R6 clock stops");
        pins(1'b1, 1'b0, 1'b0, "R8 forced idle low with inversion, R9");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1; rst_n = 1'b1;
        m = 8'h01;
        push("R1 reset value after second reset");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule